// File: doc/BRIEF.md
# PCI Base Address Region Decoder

This block decides which of a function's base address regions, if any, owns an incoming transaction. It is given the base and size of six regions, a two-bit kind for each region slot, and the function's 16-bit command register. For a request address and a space flag (I/O or memory), it reports a hit, the number of the claiming region, and the offset of the address inside that region. The decode is purely combinational, so a request can be routed in the same cycle it is presented.

Only regions whose space is enabled in the command register take part. A slot marked unused, or one that holds the upper half of a 64-bit memory region, never claims anything. When several regions overlap, the lowest-numbered one wins.

The block also watches the configuration write strobes. A write to the command register or to any region register produces a registered one-clock pulse, which tells the interconnect to rebuild its routing tables. The region registers themselves and all data movement sit outside this block.

Top module: `pci_bar_decoder`

## Requirements
- R1: Only command bit 0 (I/O enable) and bit 1 (memory enable) affect decoding; bus-master bit 2, reserved bits 15:10 and all other bits have no effect on any decode output.
- R2: A slot of kind I/O (code 1) claims only requests with `req_is_io` = 1, and only while command bit 0 is set.
- R3: A slot of kind memory (code 2) claims only requests with `req_is_io` = 0, and only while command bit 1 is set.
- R4: An enabled slot claims an address when base <= address < base + size, with the sum taken without wrap-around; a slot of size zero never claims.
- R5: When more than one slot claims, `hit_num` gives the lowest-numbered claiming slot.
- R6: On a hit, `hit_offset` equals the request address minus the base of the slot named by `hit_num`.
- R7: Slots of kind unused (code 0) and upper-half (code 3) never claim; with no claimant `hit` is 0.
- R8: `range_update` is 1 in exactly the clock cycle after a cycle in which `cmd_wr` or any bit of `bar_wr` is 1, and 0 otherwise, including after reset.
- R9: `hit`, `hit_num` and `hit_offset` follow the request and configuration inputs within the same cycle, with no register in the path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_reg | input | 16 | Current command register value |
| slot_base | input | 6*32 | Base address of each slot, slot 0 in the low bits |
| slot_size | input | 6*32 | Size in bytes of each slot |
| slot_kind | input | 6*2 | Kind per slot: 0 unused, 1 I/O, 2 memory, 3 upper half |
| req_addr | input | 32 | Transaction address |
| req_is_io | input | 1 | 1 for an I/O-space request, 0 for memory space |
| cmd_wr | input | 1 | Strobe: command register written this cycle |
| bar_wr | input | 6 | Strobe per slot: region register written this cycle |
| hit | output | 1 | Some slot claims the request |
| hit_num | output | 3 | Number of the claiming slot (valid when hit) |
| hit_offset | output | 32 | Address minus base of the claiming slot (valid when hit) |
| range_update | output | 1 | One-cycle request to refresh routing |

## Verification
The bench drives overlapping regions of both kinds so that a design picking the highest rather than the lowest match, or ignoring the space flag, reports the wrong slot number. It probes the first byte, the last byte, one byte past the end and one byte below each region, which catches an off-by-one bound that would claim a neighbouring address or drop the last one. A region ending exactly at the top of the address space exposes a bound computed with wrap-around, which would turn that region into a permanent miss, and a zero-size slot plus an upper-half slot sharing a live range show a design that forgets to exclude them. Write strobes held for a single cycle and back to back check that the refresh pulse lands one cycle late and never sticks.

// File: rtl/pci_bar_dec_pkg.sv
package pci_bar_dec_pkg;

    localparam int NUM_SLOTS = 6;
    localparam int ADDR_W    = 32;
    localparam int NUM_W     = $clog2(NUM_SLOTS);

    // Kind of region held in each slot
    typedef enum logic [1:0] {
        KIND_UNUSED = 2'd0,
        KIND_IO     = 2'd1,
        KIND_MEM    = 2'd2,
        KIND_UPPER  = 2'd3
    } slot_kind_e;

    // Space enable bits of the command register
    localparam int CMD_IO_EN_BIT  = 0;
    localparam int CMD_MEM_EN_BIT = 1;

    typedef struct packed {
        logic              hit;
        logic [NUM_W-1:0]  num;
        logic [ADDR_W-1:0] offset;
    } dec_result_t;

    // True when a slot of this kind may claim a request of the given space
    function automatic logic kind_enabled(slot_kind_e kind, logic io_en,
                                          logic mem_en, logic is_io);
        case (kind)
            KIND_IO:  return io_en & is_io;
            KIND_MEM: return mem_en & ~is_io;
            default:  return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/bar_slot_match.sv
module bar_slot_match
    import pci_bar_dec_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] size,
    input  slot_kind_e    kind,
    input  logic          io_en,
    input  logic          mem_en,
    input  logic [AW-1:0] addr,
    input  logic          is_io,
    output logic          claim
);
    logic [AW:0] limit;
    logic        in_range;

    always_comb begin
        limit    = {1'b0, base} + {1'b0, size};
        in_range = (addr >= base) && ({1'b0, addr} < limit);
        claim    = in_range && kind_enabled(kind, io_en, mem_en, is_io);
    end
endmodule

// File: rtl/bar_prio_pick.sv
module bar_prio_pick
    import pci_bar_dec_pkg::*;
#(
    parameter int NS = NUM_SLOTS,
    parameter int AW = ADDR_W,
    parameter int NW = $clog2(NS)
) (
    input  logic [NS-1:0]    claims,
    input  logic [NS*AW-1:0] bases,
    input  logic [AW-1:0]    addr,
    output logic             hit,
    output logic [NW-1:0]    num,
    output logic [AW-1:0]    offset
);
    logic [AW-1:0] sel_base;

    always_comb begin
        hit      = 1'b0;
        num      = '0;
        sel_base = '0;
        // Walk downward so the lowest claiming slot is the last one written
        for (int i = NS - 1; i >= 0; i--) begin
            if (claims[i]) begin
                hit      = 1'b1;
                num      = NW'(i);
                sel_base = bases[i*AW +: AW];
            end
        end
        offset = addr - sel_base;
    end
endmodule

// File: rtl/range_change_pulse.sv
module range_change_pulse #(
    parameter int NS = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_wr,
    input  logic [NS-1:0] bar_wr,
    output logic          pulse
);
    always_ff @(posedge clk) begin
        if (rst) pulse <= 1'b0;
        else     pulse <= cmd_wr | (|bar_wr);
    end
endmodule

// File: rtl/pci_bar_decoder.sv
module pci_bar_decoder
    import pci_bar_dec_pkg::*;
#(
    parameter int NS = NUM_SLOTS,
    parameter int AW = ADDR_W,
    parameter int NW = $clog2(NS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [15:0]      cmd_reg,
    input  logic [NS*AW-1:0] slot_base,
    input  logic [NS*AW-1:0] slot_size,
    input  logic [NS*2-1:0]  slot_kind,
    input  logic [AW-1:0]    req_addr,
    input  logic             req_is_io,
    input  logic             cmd_wr,
    input  logic [NS-1:0]    bar_wr,
    output logic             hit,
    output logic [NW-1:0]    hit_num,
    output logic [AW-1:0]    hit_offset,
    output logic             range_update
);
    logic          io_en;
    logic          mem_en;
    logic [NS-1:0] claims;

    assign io_en  = cmd_reg[CMD_IO_EN_BIT];
    assign mem_en = cmd_reg[CMD_MEM_EN_BIT];

    for (genvar g = 0; g < NS; g++) begin : g_slot
        bar_slot_match #(.AW(AW)) u_match (
            .base  (slot_base[g*AW +: AW]),
            .size  (slot_size[g*AW +: AW]),
            .kind  (slot_kind_e'(slot_kind[g*2 +: 2])),
            .io_en (io_en),
            .mem_en(mem_en),
            .addr  (req_addr),
            .is_io (req_is_io),
            .claim (claims[g])
        );
    end

    bar_prio_pick #(.NS(NS), .AW(AW), .NW(NW)) u_pick (
        .claims(claims),
        .bases (slot_base),
        .addr  (req_addr),
        .hit   (hit),
        .num   (hit_num),
        .offset(hit_offset)
    );

    range_change_pulse #(.NS(NS)) u_pulse (
        .clk   (clk),
        .rst   (rst),
        .cmd_wr(cmd_wr),
        .bar_wr(bar_wr),
        .pulse (range_update)
    );
endmodule

// File: rtl/pci_bar_decoder_chk.sv
module pci_bar_decoder_chk #(
    parameter int NS = 6,
    parameter int AW = 32,
    parameter int NW = $clog2(NS)
) (
    input logic             clk,
    input logic             rst,
    input logic [15:0]      cmd_reg,
    input logic [NS*AW-1:0] slot_base,
    input logic [NS*AW-1:0] slot_size,
    input logic [NS*2-1:0]  slot_kind,
    input logic [AW-1:0]    req_addr,
    input logic             req_is_io,
    input logic             cmd_wr,
    input logic [NS-1:0]    bar_wr,
    input logic             hit,
    input logic [NW-1:0]    hit_num,
    input logic [AW-1:0]    hit_offset,
    input logic             range_update
);
    logic [AW-1:0] sel_base;
    logic [AW-1:0] sel_size;
    logic [1:0]    sel_kind;

    always_comb begin
        sel_base = '0;
        sel_size = '0;
        sel_kind = '0;
        for (int i = 0; i < NS; i++) begin
            if (hit_num == NW'(i)) begin
                sel_base = slot_base[i*AW +: AW];
                sel_size = slot_size[i*AW +: AW];
                sel_kind = slot_kind[i*2 +: 2];
            end
        end
    end

    // R1
    no_space_hit_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_reg[1:0] == 2'b00) |-> !hit);

    // R2
    io_space_chk: assert property (@(posedge clk) disable iff (rst)
        (hit && sel_kind == 2'd1) |-> (req_is_io && cmd_reg[0]));

    // R3
    mem_space_chk: assert property (@(posedge clk) disable iff (rst)
        (hit && sel_kind == 2'd2) |-> (!req_is_io && cmd_reg[1]));

    // R7
    live_kind_chk: assert property (@(posedge clk) disable iff (rst)
        hit |-> (sel_kind == 2'd1 || sel_kind == 2'd2));

    // R4
    inside_region_chk: assert property (@(posedge clk) disable iff (rst)
        hit |-> ({1'b0, hit_offset} < {1'b0, sel_size}));

    // R6
    offset_sum_chk: assert property (@(posedge clk) disable iff (rst)
        hit |-> (hit_offset + sel_base == req_addr));

    // R8
    pulse_after_write_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr || bar_wr != '0) |=> range_update);

    // R8
    pulse_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!cmd_wr && bar_wr == '0) |=> !range_update);
endmodule

bind pci_bar_decoder pci_bar_decoder_chk #(.NS(NS), .AW(AW), .NW(NW)) u_chk (.*);

// File: tb/tb_pci_bar_decoder.sv
module tb_pci_bar_decoder;
    localparam int NS = 6;
    localparam int AW = 32;
    localparam int NW = 3;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [15:0]      cmd_reg = '0;
    logic [NS*AW-1:0] slot_base = '0;
    logic [NS*AW-1:0] slot_size = '0;
    logic [NS*2-1:0]  slot_kind = '0;
    logic [AW-1:0]    req_addr = '0;
    logic             req_is_io = 1'b0;
    logic             cmd_wr = 1'b0;
    logic [NS-1:0]    bar_wr = '0;
    logic             hit;
    logic [NW-1:0]    hit_num;
    logic [AW-1:0]    hit_offset;
    logic             range_update;

    int checks = 0;
    int fails  = 0;
    string cur_req = "R9";
    logic exp_pulse = 1'b0;

    always #4 clk = ~clk;

    pci_bar_decoder dut (.*);

    // Reference for the refresh pulse: a write seen at an edge shows one edge later
    always @(posedge clk) exp_pulse <= rst ? 1'b0 : (cmd_wr || bar_wr != 0);

    // Behavioural reference decode
    task automatic model(output bit m_hit, output int m_num, output longint m_off);
        m_hit = 0; m_num = 0; m_off = 0;
        for (int i = 0; i < NS; i++) begin
            longint b = slot_base[i*AW +: AW];
            longint s = slot_size[i*AW +: AW];
            longint a = req_addr;
            int k = slot_kind[i*2 +: 2];
            bit ok = (k == 1 && req_is_io && cmd_reg[0]) ||
                     (k == 2 && !req_is_io && cmd_reg[1]);
            if (!m_hit && ok && a >= b && a < b + s) begin
                m_hit = 1; m_num = i; m_off = a - b;
            end
        end
    endtask

    task automatic compare_now();
        bit m_hit; int m_num; longint m_off;
        model(m_hit, m_num, m_off);
        checks++;
        if (hit !== m_hit) begin
            fails++;
            $display("FAIL %s hit: actual %0b expected %0b addr %h io %0b", cur_req, hit, m_hit, req_addr, req_is_io);
        end
        if (m_hit) begin
            checks++;
            if (hit_num !== NW'(m_num)) begin
                fails++;
                $display("FAIL %s R5 hit_num: actual %0d expected %0d addr %h", cur_req, hit_num, m_num, req_addr);
            end
            checks++;
            if (hit_offset !== AW'(m_off)) begin
                fails++;
                $display("FAIL %s R6 hit_offset: actual %h expected %h", cur_req, hit_offset, AW'(m_off));
            end
        end
        checks++;
        if (range_update !== exp_pulse) begin
            fails++;
            $display("FAIL R8 range_update: actual %0b expected %0b", range_update, exp_pulse);
        end
    endtask

    // One cycle: check current inputs at the falling edge, then apply the next
    task automatic probe(input logic [AW-1:0] a, input logic io);
        @(negedge clk);
        compare_now();
        req_addr  = a;
        req_is_io = io;
        cmd_wr    = 1'b0;
        bar_wr    = '0;
    endtask

    task automatic set_slot(input int i, input logic [AW-1:0] b, input logic [AW-1:0] s, input logic [1:0] k);
        slot_base[i*AW +: AW] = b;
        slot_size[i*AW +: AW] = s;
        slot_kind[i*2 +: 2]   = k;
    endtask

    task automatic edges(input logic [AW-1:0] b, input logic [AW-1:0] s, input logic io);
        probe(b, io);
        probe(b + s - 1, io);
        probe(b + s, io);
        probe(b - 1, io);
    endtask

    initial begin : watchdog
        #1_000_000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        set_slot(0, 32'h0000_1000, 32'h100,  2'd1);
        set_slot(1, 32'h8000_0000, 32'h1000, 2'd2);
        set_slot(2, 32'h8000_0000, 32'h1_0000, 2'd3); // R7 upper half over live range
        set_slot(3, 32'h8000_0800, 32'h800,  2'd2);
        set_slot(4, 32'h0000_1000, 32'h400,  2'd0);   // R7 unused
        set_slot(5, 32'h0000_1080, 32'h80,   2'd1);
        repeat (3) @(posedge clk);
        @(negedge clk);
        checks++;
        if (hit !== 1'b0 || range_update !== 1'b0) begin
            fails++;
            $display("FAIL R8 reset: actual hit %0b pulse %0b expected 0 0", hit, range_update);
        end
        rst = 1'b0;

        cur_req = "R1";
        cmd_reg = 16'hFC04; // reserved and bus-master only: nothing decodes
        probe(32'h0000_1000, 1'b1);
        probe(32'h8000_0000, 1'b0);
        probe(32'h8000_0900, 1'b0);

        cur_req = "R2";
        cmd_reg = 16'h0001;
        edges(32'h0000_1000, 32'h100, 1'b1);
        probe(32'h8000_0010, 1'b0); // memory disabled
        probe(32'h0000_1010, 1'b0); // I/O slot, memory request

        cur_req = "R3";
        cmd_reg = 16'h0002;
        edges(32'h8000_0000, 32'h1000, 1'b0);
        probe(32'h0000_1010, 1'b1);
        probe(32'h8000_0010, 1'b1);

        cur_req = "R5";
        cmd_reg = 16'hFC07;
        probe(32'h8000_0900, 1'b0);
        probe(32'h8000_0FFF, 1'b0);
        probe(32'h0000_10A0, 1'b1);
        probe(32'h0000_1100, 1'b1);
        probe(32'h8000_1000, 1'b0); // R7 only upper-half slot covers it

        cur_req = "R4";
        set_slot(4, 32'hFFFF_F000, 32'h1000, 2'd2);
        edges(32'hFFFF_F000, 32'h1000, 1'b0);
        probe(32'hFFFF_FFFF, 1'b0);
        set_slot(4, 32'h0000_2000, 32'h0, 2'd1);
        probe(32'h0000_2000, 1'b1);
        probe(32'h0000_2000, 1'b1);

        cur_req = "R8";
        probe(32'h0, 1'b0);
        cmd_wr = 1'b1;
        probe(32'h0, 1'b0);
        probe(32'h0, 1'b0);
        probe(32'h0, 1'b0);
        bar_wr = 6'b100000;
        @(negedge clk); compare_now(); bar_wr = 6'b000001;
        @(negedge clk); compare_now(); bar_wr = '0;
        probe(32'h0, 1'b0);
        probe(32'h0, 1'b0);

        cur_req = "R9";
        for (int n = 0; n < 400; n++) begin
            logic [AW-1:0] a;
            a = (n % 2) ? (32'h8000_0000 + 32'($urandom_range(0, 32'h1200)))
                        : (32'h0000_0F00 + 32'($urandom_range(0, 32'h300)));
            cmd_reg = 16'($urandom);
            @(negedge clk);
            compare_now();
            req_addr  = a;
            req_is_io = $urandom_range(0, 1);
            cmd_wr    = ($urandom_range(0, 3) == 0);
            bar_wr    = ($urandom_range(0, 3) == 0) ? 6'($urandom) : '0;
        end
        @(negedge clk);
        compare_now();

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule